// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This block holds two independent down-counting timers: a general-purpose timer and a real-time clock. Each one chains a prescaler with a counter. The prescaler divides the clock, and each prescaler underflow steps the counter once. When the counter runs out, the timer raises a one-cycle interrupt pulse on its own pin. The timer then either reloads and runs again, or parks at zero.

Software reaches the block through a simple memory-mapped register bus. Each timer has a preset register for its prescaler and one for its counter; writing a preset changes only the preset. Reading the same offset returns the live value. Both timers are driven from one shared, write-only control word that holds a 4-bit field per timer. In each field, two bits keep their value as mode state (reload-at-zero and count-enable). The other two bits are one-shot commands that copy a preset into the live register and start the timer. A byte-lane strobe on the bus selects which timer's field a control write touches, so one timer can be reprogrammed without disturbing the other.

Top module: `tmr_dual_unit`

## Requirements
- R1: A bus write to a preset offset changes only that preset, never the live value. The offsets are: general-purpose timer counter 0x88, general-purpose timer prescaler 0x8C, real-time clock counter 0x80, real-time clock prescaler 0x84. A read of each of these offsets returns the live value, zero-extended.
- R2: While a timer is enabled and running, its prescaler decrements once per clock. When the prescaler is at zero, it reloads from its preset and produces one tick. A tick therefore occurs every preset+1 cycles.
- R3: Each tick decrements the counter. A tick that finds the counter at zero is an expiry. With counter preset C and prescaler preset S, expiries occur every (C+1)*(S+1) cycles.
- R4: With bit 0 of the timer's control field set, an expiry reloads the counter from its preset and counting continues.
- R5: With bit 0 clear, an expiry leaves the counter at zero and stops the timer. The timer then produces no further pulses until a load command arrives.
- R6: Writing 1 to bit 1 of a timer's control field copies the counter preset into the counter and starts the timer. Writing 0 to that bit leaves the counter untouched.
- R7: Writing 1 to bit 3 of a timer's control field copies the prescaler preset into the prescaler and starts the timer.
- R8: While bit 2 of a timer's control field is 0, both the prescaler and the counter of that timer hold their values.
- R9: A control write that carries a load command takes priority over that timer's count step in the same cycle. The loaded value is what appears after that edge.
- R10: The control word sits at offset 0x98. Bits 3:0 form the general-purpose timer field and are applied only when byte strobe 0 is set. Bits 11:8 form the real-time clock field and are applied only when byte strobe 1 is set. A control write therefore leaves the other timer's state and counting unchanged.
- R11: Each expiry drives the timer's interrupt pin (irq_gpt, or irq_rtc) high for exactly the one cycle following the expiring edge.
- R12: After reset, all live values, presets and mode bits are zero, both interrupt pins are low, and both timers are stopped. Reads of the control offset or of any unmapped offset return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the read cycle |
| irq_gpt | output | 1 | General-purpose timer expiry pulse |
| irq_rtc | output | 1 | Real-time clock expiry pulse |

## Verification
The bench builds the unit with an 8-bit counter and a 4-bit prescaler. Random presets are drawn from 0..7 and 0..3, which keeps expiry periods between 1 and 32 cycles. With periods that short, the random phase reaches many reload and stop expiries, counters sitting at zero, and loads that land in the same cycle as a tick. Presets of zero are included, which gives an expiry on every cycle and back-to-back interrupt pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BUS_ADDR_W = 8;
  localparam int BUS_DATA_W = 32;
  localparam int BUS_BE_W   = BUS_DATA_W / 8;
  localparam int NUM_CH     = 2;

  // channel indices
  localparam int CH_GPT = 0;
  localparam int CH_RTC = 1;

  // register offsets decoded by the unit
  localparam logic [BUS_ADDR_W-1:0] OFS_RTC_CNT = 8'h80;
  localparam logic [BUS_ADDR_W-1:0] OFS_GPT_CNT = 8'h88;
  localparam logic [BUS_ADDR_W-1:0] OFS_CTRL    = 8'h98;
  localparam logic [BUS_ADDR_W-1:0] SCL_STRIDE  = 8'h04;

  // bit meanings inside each 4-bit control field
  localparam int FLD_RELOAD = 0;
  localparam int FLD_LD_CNT = 1;
  localparam int FLD_ENABLE = 2;
  localparam int FLD_LD_SCL = 3;
  localparam int FLD_W      = 4;
  localparam int FLD_STRIDE = 8;   // field of channel c starts at bit c*8

  typedef struct packed {
    logic             ctl_wr;      // control word applies to this channel
    logic [FLD_W-1:0] field;
    logic             cnt_pre_wr;
    logic             scl_pre_wr;
  } tmr_cmd_t;

  function automatic logic [BUS_ADDR_W-1:0] cnt_offset(input int ch);
    return (ch == CH_GPT) ? OFS_GPT_CNT : OFS_RTC_CNT;
  endfunction

  function automatic logic [BUS_ADDR_W-1:0] scl_offset(input int ch);
    return cnt_offset(ch) + SCL_STRIDE;
  endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_pkg::*;
(
  input  logic                              bus_sel,
  input  logic                              bus_we,
  input  logic [BUS_ADDR_W-1:0]             bus_addr,
  input  logic [BUS_BE_W-1:0]               bus_be,
  input  logic [NUM_CH-1:0][FLD_W-1:0]      ctl_fields,
  output tmr_cmd_t [NUM_CH-1:0]             cmd
);

  logic wr_cycle;
  logic ctl_hit;

  assign wr_cycle = bus_sel && bus_we;
  assign ctl_hit  = wr_cycle && (bus_addr == OFS_CTRL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // byte lane c carries the field of channel c
    assign cmd[c].ctl_wr     = ctl_hit && bus_be[c];
    assign cmd[c].field      = ctl_fields[c];
    assign cmd[c].cnt_pre_wr = wr_cycle && (bus_addr == cnt_offset(c));
    assign cmd[c].scl_pre_wr = wr_cycle && (bus_addr == scl_offset(c));
  end

  if (BUS_BE_W > NUM_CH) begin : g_spare_lanes
    logic spare_unused;
    assign spare_unused = ^bus_be[BUS_BE_W-1:NUM_CH];
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SCL_W-1:0] preset,
  output logic [SCL_W-1:0] value,
  output logic             tick
);

  logic at_zero;

  assign at_zero = (value == '0);
  assign tick    = step && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= preset;
    end else if (step) begin
      value <= at_zero ? preset : value - 1'b1;
    end
  end

endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] value,
  output logic             expire
);

  assign expire = tick && (value == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (load) begin
      value <= preset;
    end else if (expire) begin
      if (reload_mode) value <= preset;
    end else if (tick) begin
      value <= value - 1'b1;
    end
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [SCL_W-1:0] scl_wdata,
  output logic [CNT_W-1:0] cnt_val,
  output logic [SCL_W-1:0] scl_val,
  output logic [CNT_W-1:0] cnt_pre,
  output logic             en_q,
  output logic             run_q,
  output logic             ld_cnt,
  output logic             ld_scl,
  output logic             irq
);

  logic [SCL_W-1:0] scl_pre;
  logic             reload_q;
  logic             step;
  logic             tick;
  logic             expire;

  assign ld_cnt = cmd.ctl_wr && cmd.field[FLD_LD_CNT];
  assign ld_scl = cmd.ctl_wr && cmd.field[FLD_LD_SCL];
  // a load command pre-empts this cycle's count step
  assign step   = en_q && run_q && !(ld_cnt || ld_scl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_pre <= '0;
      scl_pre <= '0;
    end else begin
      if (cmd.cnt_pre_wr) cnt_pre <= cnt_wdata;
      if (cmd.scl_pre_wr) scl_pre <= scl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      reload_q <= 1'b0;
    end else if (cmd.ctl_wr) begin
      en_q     <= cmd.field[FLD_ENABLE];
      reload_q <= cmd.field[FLD_RELOAD];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (ld_cnt || ld_scl) begin
      run_q <= 1'b1;
    end else if (expire && !reload_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= expire;
  end

  tmr_prescaler #(.SCL_W(SCL_W)) u_scl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld_scl),
    .step   (step),
    .preset (scl_pre),
    .value  (scl_val),
    .tick   (tick)
  );

  tmr_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (ld_cnt),
    .tick        (tick),
    .reload_mode (reload_q),
    .preset      (cnt_pre),
    .value       (cnt_val),
    .expire      (expire)
  );

endmodule

// File: rtl/tmr_dual_unit.sv
module tmr_dual_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [BUS_BE_W-1:0]   bus_be,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  output logic [BUS_DATA_W-1:0] bus_rdata,
  output logic                  irq_gpt,
  output logic                  irq_rtc
);

  tmr_cmd_t [NUM_CH-1:0]             cmd;
  logic [NUM_CH-1:0][FLD_W-1:0]      ctl_fields;
  logic [NUM_CH-1:0][CNT_W-1:0]      cur_cnt;
  logic [NUM_CH-1:0][SCL_W-1:0]      cur_scl;
  logic [NUM_CH-1:0][CNT_W-1:0]      cnt_pre;
  logic [NUM_CH-1:0]                 en_q;
  logic [NUM_CH-1:0]                 run_q;
  logic [NUM_CH-1:0]                 ld_cnt;
  logic [NUM_CH-1:0]                 ld_scl;
  logic [NUM_CH-1:0]                 irq_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fld
    assign ctl_fields[c] = bus_wdata[c*FLD_STRIDE +: FLD_W];
  end

  tmr_bus_decode u_dec (
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .ctl_fields (ctl_fields),
    .cmd        (cmd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tmr
    tmr_channel #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd[c]),
      .cnt_wdata (bus_wdata[CNT_W-1:0]),
      .scl_wdata (bus_wdata[SCL_W-1:0]),
      .cnt_val   (cur_cnt[c]),
      .scl_val   (cur_scl[c]),
      .cnt_pre   (cnt_pre[c]),
      .en_q      (en_q[c]),
      .run_q     (run_q[c]),
      .ld_cnt    (ld_cnt[c]),
      .ld_scl    (ld_scl[c]),
      .irq       (irq_vec[c])
    );
  end

  // live values are read back at the preset offsets; control reads as zero
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (bus_addr == cnt_offset(c)) bus_rdata = BUS_DATA_W'(cur_cnt[c]);
        if (bus_addr == scl_offset(c)) bus_rdata = BUS_DATA_W'(cur_scl[c]);
      end
    end
  end

  assign irq_gpt = irq_vec[CH_GPT];
  assign irq_rtc = irq_vec[CH_RTC];

endmodule

// File: rtl/tmr_dual_checker.sv
module tmr_dual_checker
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SCL_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0][CNT_W-1:0] cur_cnt,
  input logic [NUM_CH-1:0][SCL_W-1:0] cur_scl,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_pre,
  input logic [NUM_CH-1:0]            en_q,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0]            ld_cnt,
  input logic [NUM_CH-1:0]            ld_scl,
  input logic [NUM_CH-1:0]            irq_vec
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R8: a disabled timer with no load command keeps both live values
    a_r8_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[c] && !ld_cnt[c] && !ld_scl[c]) |=> ($stable(cur_cnt[c]) && $stable(cur_scl[c])));

    // R5: a stopped timer without a load command raises no pulse
    a_r5_stopped_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[c] && !ld_cnt[c] && !ld_scl[c]) |=> !irq_vec[c]);

    // R3: a pulse follows only a cycle in which the counter was at zero
    a_r3_pulse_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
      irq_vec[c] |-> ($past(cur_cnt[c]) == '0));

    // R6: a counter load command leaves the preset in the counter
    a_r6_load_takes_preset: assert property (@(posedge clk) disable iff (!rst_n)
      ld_cnt[c] |=> (cur_cnt[c] == $past(cnt_pre[c])));
  end

endmodule

bind tmr_dual_unit tmr_dual_checker #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cur_cnt (cur_cnt),
  .cur_scl (cur_scl),
  .cnt_pre (cnt_pre),
  .en_q    (en_q),
  .run_q   (run_q),
  .ld_cnt  (ld_cnt),
  .ld_scl  (ld_scl),
  .irq_vec (irq_vec)
);

// File: tb/tmr_dual_unit_test.sv
module tmr_dual_unit_test;

  localparam int CW = 8;
  localparam int SW = 4;
  localparam int CMASK = (1 << CW) - 1;
  localparam int SMASK = (1 << SW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_gpt;
  logic        irq_rtc;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tmr_dual_unit #(.CNT_W(CW), .SCL_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_gpt(irq_gpt), .irq_rtc(irq_rtc)
  );

  // ---------------- reference model (index 0 = GPT, 1 = RTC) -------------
  int m_cnt[2], m_scl[2], m_cpre[2], m_spre[2];
  bit m_en[2], m_rl[2], m_run[2], m_irq[2];

  function automatic int cnt_ofs(int ch);
    return (ch == 0) ? 32'h88 : 32'h80;
  endfunction

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_cnt[c] = 0; m_scl[c] = 0; m_cpre[c] = 0; m_spre[c] = 0;
      m_en[c] = 0; m_rl[c] = 0; m_run[c] = 0; m_irq[c] = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    for (int c = 0; c < 2; c++) begin
      bit wr, ctl, ldc, lds, stp, tck, exp_;
      bit [3:0] fld;
      if (!rst_n) begin
        m_cnt[c] = 0; m_scl[c] = 0; m_cpre[c] = 0; m_spre[c] = 0;
        m_en[c] = 0; m_rl[c] = 0; m_run[c] = 0; m_irq[c] = 0;
      end else begin
        wr   = bus_sel && bus_we;
        ctl  = wr && bus_addr == 8'h98 && bus_be[c];
        fld  = bus_wdata[c*8 +: 4];
        ldc  = ctl && fld[1];
        lds  = ctl && fld[3];
        stp  = m_en[c] && m_run[c] && !ldc && !lds;
        tck  = stp && m_scl[c] == 0;
        exp_ = tck && m_cnt[c] == 0;
        m_irq[c] = exp_;
        if (lds) m_scl[c] = m_spre[c];
        else if (stp) m_scl[c] = (m_scl[c] == 0) ? m_spre[c] : m_scl[c] - 1;
        if (ldc) m_cnt[c] = m_cpre[c];
        else if (exp_) begin if (m_rl[c]) m_cnt[c] = m_cpre[c]; end
        else if (tck) m_cnt[c] = m_cnt[c] - 1;
        if (ldc || lds) m_run[c] = 1;
        else if (exp_ && !m_rl[c]) m_run[c] = 0;
        if (ctl) begin m_en[c] = fld[2]; m_rl[c] = fld[0]; end
        if (wr && bus_addr == cnt_ofs(c)) m_cpre[c] = bus_wdata & CMASK;
        if (wr && bus_addr == cnt_ofs(c) + 4) m_spre[c] = bus_wdata & SMASK;
      end
    end
  end

  function automatic int exp_read(bit [7:0] a);
    case (a)
      8'h88: return m_cnt[0];
      8'h8C: return m_scl[0];
      8'h80: return m_cnt[1];
      8'h84: return m_scl[1];
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // R11: pulse pins follow the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_gpt == m_irq[0], "R11 irq_gpt", irq_gpt, m_irq[0]);
      chk(irq_rtc == m_irq[1], "R11 irq_rtc", irq_rtc, m_irq[1]);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
    end
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d, bit [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
  endtask

  task automatic rd(bit [7:0] a, string req, output int val);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    val = bus_rdata;
    chk(bus_rdata == exp_read(a), req, bus_rdata, exp_read(a));
  endtask

  task automatic wait_pulse(int ch, output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
      if ((ch == 0 ? irq_gpt : irq_rtc) == 1'b1) begin at = cyc; break; end
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int v, v2, t0, t1, n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12: reset state and unmapped reads
    rd(8'h88, "R12 reset gpt cnt", v);  chk(v == 0, "R12 gpt cnt zero", v, 0);
    rd(8'h8C, "R12 reset gpt scl", v);
    rd(8'h80, "R12 reset rtc cnt", v);
    rd(8'h84, "R12 reset rtc scl", v);
    rd(8'h98, "R12 ctrl reads zero", v);
    chk(irq_gpt == 0 && irq_rtc == 0, "R12 irq low", irq_gpt, 0);

    // R1: preset writes leave live values alone
    wr(8'h8C, 2); wr(8'h88, 3);
    rd(8'h88, "R1 preset does not touch live", v); chk(v == 0, "R1 live cnt", v, 0);

    // R2 R3 R4 R7: reload mode period = (3+1)*(2+1) = 12
    wr(8'h98, 32'h0F, 4'b0001);
    wait_pulse(0, t0); wait_pulse(0, t1);
    chk(t1 - t0 == 12, "R3 R2 R4 period", t1 - t0, 12);

    // R5: stop at zero
    wr(8'h98, 32'h06, 4'b0001);
    wait_pulse(0, t0);
    chk(t0 >= 0, "R5 first pulse seen", t0, 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); bus_sel = 0; if (irq_gpt) n++;
    end
    chk(n == 0, "R5 no pulse after stop", n, 0);
    rd(8'h88, "R5 parked at zero", v); chk(v == 0, "R5 counter zero", v, 0);

    // R8: hold while disabled
    wr(8'h98, 32'h0F, 4'b0001);
    idle(5);
    wr(8'h98, 32'h0B, 4'b0001);  // loads, enable clear
    idle(2);
    rd(8'h88, "R8 held cnt", v);
    idle(10);
    rd(8'h88, "R8 held cnt later", v2); chk(v == v2, "R8 counter held", v2, v);

    // R6: enable without load bits keeps the held counter
    wr(8'h98, 32'h05, 4'b0001);
    rd(8'h88, "R6 zero load bit no effect", v2); chk(v == v2, "R6 counter kept", v2, v);

    // R9: load beats the count step
    wr(8'h8C, 0); wr(8'h88, 5);
    wr(8'h98, 32'h0F, 4'b0001);
    idle(2);
    wr(8'h98, 32'h0F, 4'b0001);
    rd(8'h88, "R9 load wins", v); chk(v == 5, "R9 loaded value", v, 5);

    // R10: RTC runs with period (2+1)*(1+1) = 6; GPT-only writes leave it alone
    wr(8'h84, 1); wr(8'h80, 2);
    wr(8'h98, 32'h0F00, 4'b0010);
    wait_pulse(1, t0);
    wr(8'h98, 32'h0000_000F, 4'b0001);
    wait_pulse(1, t1); wait_pulse(1, t0);
    chk(t0 - t1 == 6, "R10 rtc period unchanged", t0 - t1, 6);

    // R12: unmapped write has no effect
    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h80, "R12 unmapped write", v);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: idle(1);
        3, 4: begin
          bit [7:0] a;
          case ($urandom_range(0, 5))
            0: a = 8'h80; 1: a = 8'h84; 2: a = 8'h88; 3: a = 8'h8C;
            4: a = 8'h98; default: a = 8'h9C;
          endcase
          rd(a, "R1 random read", v);
        end
        5: wr(8'h88, $urandom_range(0, 7));
        6: wr(8'h80, $urandom_range(0, 7));
        7: wr($urandom_range(0, 1) ? 8'h8C : 8'h84, $urandom_range(0, 3));
        default: wr(8'h98, $urandom & 32'h0F0F, 4'($urandom));
      endcase
    end
    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule